// File: doc/BRIEF.md
# Framed Serial Link Transceiver

This block moves fixed-length frames over a one-bit serial line, one line in each direction, such as an optical fibre transmitter and receiver. A frame holds an 8-bit command, an 8-bit address and a 32-bit data word. The block sends these as six characters. Each character carries a start bit, eight data bits, an even-parity bit and a stop bit, so a frame is 66 line bits long. The transmit side takes the three fields on a single start strobe and shifts them out, holding each bit for a fixed number of clock cycles.

The receive side first brings the incoming line into the clock domain. It then finds start bits and samples every bit at its middle, using a clock that runs at a whole multiple of the bit rate. It rebuilds the six characters and ends each frame with a one-cycle pulse. That pulse is one of three kinds: good frame, parity error, or framing error. A link monitor watches the same line and keeps a flag showing whether the far end is present. The flag is raised by a long high idle or by any good frame. It is cleared by a long stretch of low line.

At the default of 8 clocks per bit with a 40 MHz clock, the line runs at 5 Mbit/s. A frame then lasts about 13 µs. The presence timeouts default to 10 µs of high line to raise the flag and 20 µs of low line to clear it.

Top module: `sfl_link`

## Requirements
- R1: A frame on `tx_line` is six 11-bit characters: command, address, then data bits 7:0, 15:8, 23:16 and 31:24. Each character is sent as a start bit 0, then the eight bits least significant first, then a parity bit equal to the XOR of those eight bits, then a stop bit 1.
- R2: Every line bit lasts `OVS` clock cycles, so `tx_busy` stays high for exactly 66·`OVS` cycles. While `tx_busy` is low, `tx_line` is 1.
- R3: A `tx_start` pulse that arrives while `tx_busy` is high is ignored. No second frame follows.
- R4: When a frame with correct parity and framing arrives on `rx_line`, `rx_valid` pulses for one cycle. In that same cycle, `rx_cmd`, `rx_addr` and `rx_data` hold the fields, placed as in R1.
- R5: If any character of an arriving frame has a parity mismatch, the block pulses `rx_parity_err` once at the end of the frame and does not pulse `rx_valid`.
- R6: If a stop bit is sampled as 0, the block pulses `rx_frame_err` at once and drops the partial frame. It then waits for the line to go high before it looks for the next start bit.
- R7: If the line stays idle for `GAP_BITS` bit times between two characters of one frame, the partial frame is dropped without any pulse.
- R8: Coming out of reset, `link_up` becomes 1 once the line has been high for `IDLE_HIGH_CYC` consecutive cycles.
- R9: `link_up` becomes 0 once the line has been low for `LOW_ABSENT_CYC` consecutive cycles.
- R10: A good frame (`rx_valid`) sets `link_up` in the next cycle, however long the line was high before it.
- R11: At most one of `rx_valid`, `rx_parity_err` and `rx_frame_err` is high in any cycle.
- R12: During reset, `tx_line` is 1, while `tx_busy`, `link_up` and all receive pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at `OVS` times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Strobe to send one frame |
| tx_cmd | input | 8 | Command field to send |
| tx_addr | input | 8 | Address field to send |
| tx_data | input | 32 | Data field to send |
| tx_busy | output | 1 | A frame is being shifted out |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | One-cycle pulse: good frame received |
| rx_parity_err | output | 1 | One-cycle pulse: frame ended with a parity error |
| rx_frame_err | output | 1 | One-cycle pulse: a stop bit read 0 |
| rx_cmd | output | 8 | Received command, valid with `rx_valid` |
| rx_addr | output | 8 | Received address, valid with `rx_valid` |
| rx_data | output | 32 | Received data, valid with `rx_valid` |
| link_up | output | 1 | The far end is present |

## Verification
The transmitter and the receiver share a clock but no other state. The bench therefore starts a request on `tx_line` in the same cycle that it begins driving a reply into `rx_line`. It then checks that the decoded outgoing bits and the received fields both match what was sent. A second overlap is between the receiver and the link monitor. A frame arrives right after a long low stretch has cleared `link_up`, so the cycle that ends the frame is also the cycle in which presence must be raised again. The bench judges this by reading `link_up` before and after the frame.

// File: rtl/sfl_pkg.sv
// Package for the framed serial link.
// It holds the fixed frame geometry, the frame record and the function
// that turns a frame into its line bits.
// Assumes: six characters, each with start, eight data, parity and stop bits.
package sfl_pkg;

    localparam int NUM_CHARS  = 6;
    localparam int CHAR_BITS  = 11;
    localparam int FRAME_BITS = NUM_CHARS * CHAR_BITS;
    localparam int BODY_BITS  = 8 * NUM_CHARS;

    // Frame fields; cmd sits in the lowest byte so byte k is character k.
    typedef struct packed {
        logic [31:0] data;
        logic [7:0]  addr;
        logic [7:0]  cmd;
    } sfl_frame_t;

    // Build the 66 line bits, bit 0 leaves first.
    function automatic logic [FRAME_BITS-1:0] sfl_pack(input sfl_frame_t f);
        logic [BODY_BITS-1:0]  body;
        logic [FRAME_BITS-1:0] w;
        body = {f.data, f.addr, f.cmd};
        for (int i = 0; i < NUM_CHARS; i++) begin
            w[i*CHAR_BITS +: CHAR_BITS] = {1'b1, ^body[i*8 +: 8], body[i*8 +: 8], 1'b0};
        end
        return w;
    endfunction

endpackage

// File: rtl/sfl_tx.sv
// Transmit serializer.
// On an accepted start strobe it captures a frame and shifts its 66 line
// bits out, holding each bit for OVS cycles.
// Assumes: OVS >= 4; strobes arriving while busy are dropped.
module sfl_tx
    import sfl_pkg::*;
#(
    parameter int OVS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  sfl_frame_t frame_in,
    output logic       busy,
    output logic       line
);
    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] packed_bits;
    logic [FRAME_BITS-1:0] shreg;
    logic [CW-1:0]         tick;
    logic [BW-1:0]         bitn;

    // Form the line image of the offered frame.
    always_comb packed_bits = sfl_pack(frame_in);

    // Accept a frame when idle, then step one bit every OVS cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            line  <= 1'b1;
            shreg <= '0;
            tick  <= '0;
            bitn  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                line  <= packed_bits[0];
                shreg <= packed_bits >> 1;
                tick  <= '0;
                bitn  <= '0;
            end
        end else if (tick == CW'(OVS-1)) begin
            tick <= '0;
            if (bitn == BW'(FRAME_BITS-1)) begin
                busy <= 1'b0;
                line <= 1'b1;
            end else begin
                line  <= shreg[0];
                shreg <= shreg >> 1;
                bitn  <= bitn + 1'b1;
            end
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/sfl_rx.sv
// Receive deserializer.
// It hunts for a start bit, confirms it at mid-bit and samples the other
// ten bits of each character at their middles. It collects six characters
// and reports one outcome per frame.
// Assumes: line is already synchronised and idles high.
module sfl_rx
    import sfl_pkg::*;
#(
    parameter int OVS      = 8,
    parameter int GAP_BITS = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line,
    output sfl_frame_t frame_out,
    output logic       ok,
    output logic       perr,
    output logic       ferr
);
    localparam int CW      = $clog2(OVS);
    localparam int HALF    = OVS / 2;
    localparam int GAP_CYC = GAP_BITS * OVS;
    localparam int GW      = $clog2(GAP_CYC + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_WAIT_HI} rx_state_t;

    rx_state_t            st;
    logic [CW-1:0]        tick;
    logic [3:0]           bitn;
    logic [2:0]           cidx;
    logic [GW-1:0]        gap;
    logic [7:0]           shreg;
    logic                 par;
    logic                 perr_acc;
    logic                 char_bad;
    logic [BODY_BITS-1:0] body;

    // A character is bad when its data and parity bits XOR to 1.
    always_comb char_bad = (^shreg) ^ par;

    assign frame_out = sfl_frame_t'(body);

    // Frame state machine: hunt, confirm start, sample bits, close characters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= RX_IDLE;
            tick     <= '0;
            bitn     <= '0;
            cidx     <= '0;
            gap      <= '0;
            shreg    <= '0;
            par      <= 1'b0;
            perr_acc <= 1'b0;
            body     <= '0;
            ok       <= 1'b0;
            perr     <= 1'b0;
            ferr     <= 1'b0;
        end else begin
            ok   <= 1'b0;
            perr <= 1'b0;
            ferr <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (!line) begin
                        st   <= RX_START;
                        tick <= '0;
                        gap  <= '0;
                    end else if (cidx != 3'd0) begin
                        if (gap == GW'(GAP_CYC-1)) begin
                            cidx     <= '0;
                            perr_acc <= 1'b0;
                            gap      <= '0;
                        end else begin
                            gap <= gap + 1'b1;
                        end
                    end
                end
                RX_START: begin
                    if (tick == CW'(HALF-1)) begin
                        tick <= '0;
                        bitn <= '0;
                        st   <= line ? RX_IDLE : RX_BITS;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                RX_BITS: begin
                    if (tick == CW'(OVS-1)) begin
                        tick <= '0;
                        bitn <= bitn + 1'b1;
                        if (bitn < 4'd8) begin
                            shreg <= {line, shreg[7:1]};
                        end else if (bitn == 4'd8) begin
                            par <= line;
                        end else if (!line) begin
                            ferr     <= 1'b1;
                            cidx     <= '0;
                            perr_acc <= 1'b0;
                            st       <= RX_WAIT_HI;
                        end else begin
                            body[int'(cidx)*8 +: 8] <= shreg;
                            st <= RX_IDLE;
                            if (cidx == 3'(NUM_CHARS-1)) begin
                                cidx     <= '0;
                                perr_acc <= 1'b0;
                                if (perr_acc || char_bad) perr <= 1'b1;
                                else                      ok   <= 1'b1;
                            end else begin
                                cidx     <= cidx + 1'b1;
                                perr_acc <= perr_acc | char_bad;
                            end
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: begin
                    if (line) st <= RX_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sfl_presence.sv
// Link presence monitor.
// It measures runs of constant line level and keeps a present flag.
// Assumes: line is synchronised; frame_ok is a one-cycle pulse.
module sfl_presence #(
    parameter int IDLE_HIGH_CYC  = 400,
    parameter int LOW_ABSENT_CYC = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic frame_ok,
    output logic up
);
    localparam int HW = $clog2(IDLE_HIGH_CYC + 1);
    localparam int LW = $clog2(LOW_ABSENT_CYC + 1);

    logic [HW-1:0] hi_run;
    logic [LW-1:0] lo_run;

    // Count consecutive high and low samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
            lo_run <= '0;
        end else if (line) begin
            lo_run <= '0;
            if (hi_run != HW'(IDLE_HIGH_CYC)) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
            if (lo_run != LW'(LOW_ABSENT_CYC)) lo_run <= lo_run + 1'b1;
        end
    end

    // Raise on a good frame or a long idle; drop on a long low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up <= 1'b0;
        end else if (frame_ok || (line && hi_run == HW'(IDLE_HIGH_CYC-1))) begin
            up <= 1'b1;
        end else if (!line && lo_run == LW'(LOW_ABSENT_CYC-1)) begin
            up <= 1'b0;
        end
    end
endmodule

// File: rtl/sfl_link.sv
// Framed serial link transceiver top.
// It joins the serializer, the deserializer behind a two-flop input
// synchroniser, and the presence monitor.
// Assumes: clk runs at OVS times the line bit rate.
module sfl_link
    import sfl_pkg::*;
#(
    parameter int OVS            = 8,
    parameter int GAP_BITS       = 3,
    parameter int IDLE_HIGH_CYC  = 400,
    parameter int LOW_ABSENT_CYC = 800
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tx_start,
    input  logic [7:0]  tx_cmd,
    input  logic [7:0]  tx_addr,
    input  logic [31:0] tx_data,
    output logic        tx_busy,
    output logic        tx_line,
    input  logic        rx_line,
    output logic        rx_valid,
    output logic        rx_parity_err,
    output logic        rx_frame_err,
    output logic [7:0]  rx_cmd,
    output logic [7:0]  rx_addr,
    output logic [31:0] rx_data,
    output logic        link_up
);
    logic       sync0, line_s;
    sfl_frame_t tx_frame, rx_frame;

    // Bring the asynchronous input into the clock domain, idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync0  <= 1'b1;
            line_s <= 1'b1;
        end else begin
            sync0  <= rx_line;
            line_s <= sync0;
        end
    end

    assign tx_frame = '{data: tx_data, addr: tx_addr, cmd: tx_cmd};

    sfl_tx #(.OVS(OVS)) i_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .frame_in(tx_frame),
        .busy(tx_busy), .line(tx_line)
    );

    sfl_rx #(.OVS(OVS), .GAP_BITS(GAP_BITS)) i_rx (
        .clk(clk), .rst_n(rst_n), .line(line_s), .frame_out(rx_frame),
        .ok(rx_valid), .perr(rx_parity_err), .ferr(rx_frame_err)
    );

    sfl_presence #(.IDLE_HIGH_CYC(IDLE_HIGH_CYC), .LOW_ABSENT_CYC(LOW_ABSENT_CYC)) i_pres (
        .clk(clk), .rst_n(rst_n), .line(line_s), .frame_ok(rx_valid), .up(link_up)
    );

    assign rx_cmd  = rx_frame.cmd;
    assign rx_addr = rx_frame.addr;
    assign rx_data = rx_frame.data;
endmodule

// File: rtl/sfl_link_chk.sv
// Property checker for sfl_link, attached by bind.
// It uses counters for windows that scale with parameters.
module sfl_link_chk #(
    parameter int OVS            = 8,
    parameter int LOW_ABSENT_CYC = 800
) (
    input logic clk,
    input logic rst_n,
    input logic tx_busy,
    input logic tx_line,
    input logic line_s,
    input logic rx_valid,
    input logic rx_parity_err,
    input logic rx_frame_err,
    input logic link_up
);
    localparam int FRAME_CYC = 66 * OVS;

    int busy_run;
    int low_run;

    // Track the length of the current busy stretch and low-line stretch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_run <= 0;
            low_run  <= 0;
        end else begin
            busy_run <= tx_busy ? busy_run + 1 : 0;
            low_run  <= line_s ? 0 : low_run + 1;
        end
    end

    p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !tx_line);
    p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> tx_line);
    p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_busy) |-> busy_run == FRAME_CYC);
    p_low_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run >= LOW_ABSENT_CYC) |-> !link_up);
    p_ok_sets_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> link_up);
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_parity_err, rx_frame_err}));
endmodule

bind sfl_link sfl_link_chk #(.OVS(OVS), .LOW_ABSENT_CYC(LOW_ABSENT_CYC)) i_chk (
    .clk(clk), .rst_n(rst_n), .tx_busy(tx_busy), .tx_line(tx_line),
    .line_s(line_s), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
    .rx_frame_err(rx_frame_err), .link_up(link_up)
);

// File: tb/test_sfl_link.sv
module test_sfl_link;
    localparam int OVS = 8;
    localparam int FB  = 66;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, tx_start, rx_line;
    logic [7:0]  tx_cmd, tx_addr;
    logic [31:0] tx_data;
    logic        tx_busy, tx_line, rx_valid, rx_parity_err, rx_frame_err, link_up;
    logic [7:0]  rx_cmd, rx_addr;
    logic [31:0] rx_data;

    sfl_link i_sfl_link (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_cmd(tx_cmd),
        .tx_addr(tx_addr), .tx_data(tx_data), .tx_busy(tx_busy), .tx_line(tx_line),
        .rx_line(rx_line), .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_cmd(rx_cmd), .rx_addr(rx_addr),
        .rx_data(rx_data), .link_up(link_up)
    );

    int checks = 0;
    int fails  = 0;

    // Expected receive outcome: kind 0 good, 1 parity error, 2 framing error.
    typedef struct {
        int          kind;
        logic [47:0] fields;
        string       req;
    } rx_item_t;

    rx_item_t          rxq[$];
    logic [FB-1:0]     txq[$];

    task automatic chk(input string req, input logic [FB-1:0] act, input logic [FB-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Line image from R1, built bit by bit.
    function automatic logic [FB-1:0] wire_of(input logic [7:0] c, input logic [7:0] a,
                                              input logic [31:0] d);
        logic [7:0]    b[6];
        logic [FB-1:0] w;
        int            ones;
        b[0] = c; b[1] = a;
        b[2] = d[7:0]; b[3] = d[15:8]; b[4] = d[23:16]; b[5] = d[31:24];
        for (int k = 0; k < 6; k++) begin
            ones = 0;
            w[k*11] = 1'b0;
            for (int j = 0; j < 8; j++) begin
                w[k*11+1+j] = b[k][j];
                ones += int'(b[k][j]);
            end
            w[k*11+9]  = ones[0];
            w[k*11+10] = 1'b1;
        end
        return w;
    endfunction

    task automatic drive_bits(input logic [FB-1:0] w, input int n);
        for (int i = 0; i < n; i++) begin
            rx_line = w[i];
            repeat (OVS) @(negedge clk);
        end
        rx_line = 1'b1;
    endtask

    // Driver: queue the expected outcome, then drive the frame.
    task automatic rx_frame(input logic [7:0] c, input logic [7:0] a, input logic [31:0] d,
                            input int bad_par, input int bad_stop, input string req);
        rx_item_t      it;
        logic [FB-1:0] w;
        w = wire_of(c, a, d);
        it.fields = {d, a, c};
        it.req    = req;
        it.kind   = 0;
        if (bad_par >= 0) begin
            w[bad_par*11+9] = ~w[bad_par*11+9];
            it.kind = 1;
        end
        if (bad_stop >= 0) begin
            w[bad_stop*11+10] = 1'b0;
            it.kind = 2;
        end
        rxq.push_back(it);
        drive_bits(w, (bad_stop >= 0) ? (bad_stop + 1) * 11 : FB);
    endtask

    // Send a request; count the cycles busy stays high.
    task automatic tx_send(input logic [7:0] c, input logic [7:0] a, input logic [31:0] d,
                           output int busy_cycles);
        @(negedge clk);
        tx_cmd = c; tx_addr = a; tx_data = d; tx_start = 1'b1;
        txq.push_back(wire_of(c, a, d));
        @(negedge clk);
        tx_start = 1'b0;
        busy_cycles = 0;
        while (tx_busy) begin
            busy_cycles++;
            @(negedge clk);
        end
    endtask

    // Receive monitor: pop the scoreboard on every outcome pulse (R4, R5, R6, R11).
    initial begin
        rx_item_t e;
        int       k;
        forever begin
            @(negedge clk);
            if (rst_n && (rx_valid || rx_parity_err || rx_frame_err)) begin
                k = rx_valid ? 0 : (rx_parity_err ? 1 : 2);
                chk("R11 single outcome", FB'(int'(rx_valid) + int'(rx_parity_err) + int'(rx_frame_err)), FB'(1));
                if (rxq.size() == 0) begin
                    chk("R7 unexpected outcome", FB'(k), FB'(99));
                end else begin
                    e = rxq.pop_front();
                    chk({e.req, " kind"}, FB'(k), FB'(e.kind));
                    if (k == 0 && e.kind == 0)
                        chk({e.req, " fields"}, FB'({rx_data, rx_addr, rx_cmd}), FB'(e.fields));
                end
            end
        end
    end

    // Transmit monitor: decode tx_line at mid-bit and compare (R1).
    initial begin
        logic [FB-1:0] got;
        forever begin
            @(negedge clk);
            if (rst_n === 1'b1 && tx_line === 1'b0) begin
                repeat (OVS/2 - 1) @(negedge clk);
                for (int i = 0; i < FB; i++) begin
                    got[i] = tx_line;
                    if (i < FB-1) repeat (OVS) @(negedge clk);
                end
                if (txq.size() == 0) chk("R3 unexpected tx frame", got, '1);
                else                 chk("R1 tx frame bits", got, txq.pop_front());
            end
        end
    end

    task automatic run_all();
        int n;
        logic [FB-1:0] partial;
        // R12 reset state
        repeat (3) @(negedge clk);
        chk("R12 tx_line", FB'(tx_line), FB'(1));
        chk("R12 tx_busy", FB'(tx_busy), FB'(0));
        chk("R12 link_up", FB'(link_up), FB'(0));
        chk("R12 pulses", FB'({rx_valid, rx_parity_err, rx_frame_err}), FB'(0));
        rst_n = 1'b1;
        // R8 idle high raises presence
        repeat (380) @(negedge clk);
        chk("R8 before idle limit", FB'(link_up), FB'(0));
        repeat (40) @(negedge clk);
        chk("R8 after idle limit", FB'(link_up), FB'(1));
        // R4 good frames
        rx_frame(8'h3C, 8'h81, 32'hDEADBEEF, -1, -1, "R4 frame a");
        rx_frame(8'h00, 8'hFF, 32'h0123_4567, -1, -1, "R4 frame b");
        // R1, R2 transmit
        tx_send(8'hA5, 8'h12, 32'h8000_0001, n);
        chk("R2 busy length", FB'(n), FB'(66*OVS));
        repeat (4) @(negedge clk);
        chk("R2 idle level", FB'(tx_line), FB'(1));
        // R3 start during busy ignored
        fork
            tx_send(8'h7E, 8'h01, 32'hCAFE_F00D, n);
            begin
                repeat (100) @(negedge clk);
                tx_cmd = 8'h11; tx_start = 1'b1;
                @(negedge clk);
                tx_start = 1'b0;
            end
        join
        repeat (200) @(negedge clk);
        chk("R3 no extra frame", FB'(txq.size()), FB'(0));
        chk("R3 line idle", FB'(tx_line), FB'(1));
        // R5 parity error, then recovery
        rx_frame(8'h55, 8'h66, 32'h7777_8888, 3, -1, "R5 parity");
        rx_frame(8'h01, 8'h02, 32'h0304_0506, -1, -1, "R5 recovery");
        // R6 framing error, then recovery
        rx_frame(8'h9A, 8'hBC, 32'h1111_2222, -1, 2, "R6 framing");
        repeat (2*OVS) @(negedge clk);
        rx_frame(8'hF0, 8'h0F, 32'hA5A5_5A5A, -1, -1, "R6 recovery");
        // R7 gap drops a partial frame silently
        partial = wire_of(8'hEE, 8'hDD, 32'hCCCC_CCCC);
        drive_bits(partial, 22);
        repeat (6*OVS) @(negedge clk);
        rx_frame(8'h42, 8'h24, 32'h1234_5678, -1, -1, "R7 after gap");
        // Overlap: request out while a reply comes in
        fork
            tx_send(8'hC3, 8'h3C, 32'hFEDC_BA98, n);
            rx_frame(8'h5A, 8'hA5, 32'h0F0F_F0F0, -1, -1, "R4 concurrent");
        join
        repeat (20) @(negedge clk);
        // R9 long low drops presence (the low line also reads as a framing error)
        begin
            rx_item_t fe;
            fe.kind = 2; fe.fields = '0; fe.req = "R6 low line";
            rxq.push_back(fe);
        end
        rx_line = 1'b0;
        repeat (700) @(negedge clk);
        chk("R9 before low limit", FB'(link_up), FB'(1));
        repeat (120) @(negedge clk);
        chk("R9 after low limit", FB'(link_up), FB'(0));
        rx_line = 1'b1;
        repeat (2*OVS) @(negedge clk);
        chk("R10 still absent", FB'(link_up), FB'(0));
        rx_frame(8'h77, 8'h88, 32'h9999_AAAA, -1, -1, "R10 frame");
        chk("R10 present after frame", FB'(link_up), FB'(1));
        repeat (50) @(negedge clk);
        chk("R4 scoreboard drained", FB'(rxq.size()), FB'(0));
        chk("R1 tx scoreboard drained", FB'(txq.size()), FB'(0));
    endtask

    initial begin
        rst_n = 1'b0; tx_start = 1'b0; rx_line = 1'b1;
        tx_cmd = '0; tx_addr = '0; tx_data = '0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule